// File: doc/BRIEF.md
# Parallel Serial-to-Parallel Register Loader

This block drives one or more chains of external serial-in/parallel-out shift registers. All chains share one shift clock, one store (latch) strobe and one clear line, and each chain has its own serial data line. A load command carries a bit count, one data word per lane and a word of trailing levels. The block shifts the selected bits out on every lane at once, moves the data lines to the trailing levels and then strobes the store line. The external registers can latch those trailing levels as an extra control, such as a brightness setting.

Two further commands act directly on the pins. One writes levels straight to the data lines without any shifting. The other pulses the clear line to erase the external registers. The active level of the shift, store and clear lines, and of each data line, is set by a parameter. A busy output stays high while a load or clear sequence runs, and any command offered during that time is dropped.

Top module: `sipo_ldr`

## Requirements
- R1: After reset, shift, store and clear sit at their inactive levels, busy is low and every data line carries logic 0 (before its polarity is applied).
- R2: The load command is cmd_op = 2'b01. It sends the low n bits of each lane's word, highest of those bits first. Each bit goes out on one shared shift pulse, and exactly n shift pulses are produced.
- R3: Each data bit is held for HALF_CYC cycles before the shift line goes active. The shift line stays active for HALF_CYC cycles. A load keeps busy high for exactly 2*HALF_CYC*n + HALF_CYC + STORE_CYC cycles.
- R4: After the last shift pulse, the data lines carry the command's trailing levels for HALF_CYC cycles before store and throughout store. They stay at those levels once idle.
- R5: Each load produces exactly one store pulse, STORE_CYC cycles long. Store is never active together with shift, and busy falls in the same cycle that store ends.
- R6: The direct-write command is cmd_op = 2'b10. It sets the data lines to cmd_lvl in the next cycle, with no shift or store activity, and busy stays low.
- R7: The clear command is cmd_op = 2'b11. It activates the clear line for CLEAR_CYC cycles, with busy high for the same cycles and no shift or store activity.
- R8: A command offered while busy is high is ignored. It does not alter the shifted bits, the trailing levels or the levels left on the data lines.
- R9: The shift, store and clear pins are active high when SHIFT_ACT, STORE_ACT and CLEAR_ACT are 1, and active low when they are 0. Data lane i is inverted at the pin when DATA_INV[i] is 1.
- R10: A load with n = 0 produces no shift pulse. It goes straight to the trailing levels and the store pulse.
- R11: A load with n greater than MAXBITS is treated as n = MAXBITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while busy is low |
| cmd_op | input | 2 | 01 load, 10 direct data write, 11 clear, 00 none |
| cmd_bits | input | $clog2(MAXBITS+1) | Bits per lane for a load |
| cmd_data | input | LANES*MAXBITS | Lane i word at [i*MAXBITS +: MAXBITS] |
| cmd_lvl | input | LANES | Trailing levels (load) or direct levels (write) |
| shift_o | output | 1 | Shared shift clock pin |
| store_o | output | 1 | Shared store strobe pin |
| clear_o | output | 1 | Shared clear pin |
| data_o | output | LANES | Serial data pins, one per chain |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the block with three lanes of 8 bits, a half period of 2 cycles, a 3-cycle store and a 2-cycle clear. The shift and clear pins are active low, and the middle data lane is inverted, so both senses of every polarity option are exercised. The 8-bit lanes with a 4-bit count make counts above the lane width reachable, so clamping can be tested. Zero-length loads and commands offered mid-sequence are also checked at the pins.

// File: rtl/sipo_ldr_pkg.sv
package sipo_ldr_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_LOAD  = 2'b01,
      OP_DATA  = 2'b10,
      OP_CLEAR = 2'b11
   } sipo_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_TRAIL,
      ST_STORE,
      ST_CLR
   } sipo_st_e;
endpackage

// File: rtl/sipo_ldr_lane.sv
module sipo_ldr_lane #(
   parameter int MAXBITS = 16,
   parameter int CW      = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               wr,
   input  logic               adv,
   input  logic               sel_sr,
   input  logic [CW-1:0]      nb,
   input  logic [MAXBITS-1:0] word,
   input  logic               lvl,
   output logic               dline
);
   logic [MAXBITS-1:0] sr_q;
   logic               hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         hold_q <= 1'b0;
      end else if (load) begin
         // left-align the n live bits so the top bit leaves first
         sr_q   <= word << (CW'(MAXBITS) - nb);
         hold_q <= lvl;
      end else if (wr) begin
         hold_q <= lvl;
      end else if (adv) begin
         sr_q   <= sr_q << 1;
      end
   end

   assign dline = sel_sr ? sr_q[MAXBITS-1] : hold_q;
endmodule

// File: rtl/sipo_ldr_ctrl.sv
module sipo_ldr_ctrl
   import sipo_ldr_pkg::*;
#(
   parameter int MAXBITS   = 16,
   parameter int HALF_CYC  = 4,
   parameter int STORE_CYC = 4,
   parameter int CLEAR_CYC = 4,
   parameter int CW        = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_op,
   input  logic [CW-1:0] cmd_bits,
   output logic [CW-1:0] nb_eff,
   output logic          lane_load,
   output logic          lane_wr,
   output logic          lane_adv,
   output logic          sel_sr,
   output logic          sclk_l,
   output logic          store_l,
   output logic          clear_l,
   output logic          busy
);
   localparam int MAXT = (HALF_CYC > STORE_CYC)
                         ? ((HALF_CYC > CLEAR_CYC) ? HALF_CYC : CLEAR_CYC)
                         : ((STORE_CYC > CLEAR_CYC) ? STORE_CYC : CLEAR_CYC);
   localparam int TW = (MAXT > 1) ? $clog2(MAXT) : 1;

   sipo_st_e      st_q;
   logic [TW-1:0] tmr_q;
   logic [CW-1:0] rem_q;
   sipo_op_e      op;
   logic          accept;
   logic          t_end;

   always_comb begin
      op        = sipo_op_e'(cmd_op);
      accept    = cmd_valid && (st_q == ST_IDLE);
      nb_eff    = (cmd_bits > CW'(MAXBITS)) ? CW'(MAXBITS) : cmd_bits;
      t_end     = (tmr_q == '0);
      lane_load = accept && (op == OP_LOAD);
      lane_wr   = accept && (op == OP_DATA);
      lane_adv  = (st_q == ST_HIGH) && t_end && (rem_q != '0);
      sel_sr    = (st_q == ST_LOW) || (st_q == ST_HIGH);
      sclk_l    = (st_q == ST_HIGH);
      store_l   = (st_q == ST_STORE);
      clear_l   = (st_q == ST_CLR);
      busy      = (st_q != ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         tmr_q <= '0;
         rem_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (lane_load) begin
                  tmr_q <= TW'(HALF_CYC - 1);
                  rem_q <= nb_eff - CW'(1);
                  st_q  <= (nb_eff == '0) ? ST_TRAIL : ST_LOW;
               end else if (accept && (op == OP_CLEAR)) begin
                  tmr_q <= TW'(CLEAR_CYC - 1);
                  st_q  <= ST_CLR;
               end
            end
            ST_LOW: begin
               if (t_end) begin
                  tmr_q <= TW'(HALF_CYC - 1);
                  st_q  <= ST_HIGH;
               end else tmr_q <= tmr_q - TW'(1);
            end
            ST_HIGH: begin
               if (t_end) begin
                  tmr_q <= TW'(HALF_CYC - 1);
                  if (rem_q == '0) st_q <= ST_TRAIL;
                  else begin
                     rem_q <= rem_q - CW'(1);
                     st_q  <= ST_LOW;
                  end
               end else tmr_q <= tmr_q - TW'(1);
            end
            ST_TRAIL: begin
               if (t_end) begin
                  tmr_q <= TW'(STORE_CYC - 1);
                  st_q  <= ST_STORE;
               end else tmr_q <= tmr_q - TW'(1);
            end
            ST_STORE, ST_CLR: begin
               if (t_end) st_q <= ST_IDLE;
               else tmr_q <= tmr_q - TW'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sipo_ldr.sv
module sipo_ldr #(
   parameter int               LANES     = 4,
   parameter int               MAXBITS   = 16,
   parameter int               HALF_CYC  = 4,
   parameter int               STORE_CYC = 4,
   parameter int               CLEAR_CYC = 4,
   parameter bit               SHIFT_ACT = 1'b1,
   parameter bit               STORE_ACT = 1'b1,
   parameter bit               CLEAR_ACT = 1'b1,
   parameter logic [LANES-1:0] DATA_INV  = '0,
   localparam int              CW        = $clog2(MAXBITS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   input  logic [1:0]               cmd_op,
   input  logic [CW-1:0]            cmd_bits,
   input  logic [LANES*MAXBITS-1:0] cmd_data,
   input  logic [LANES-1:0]         cmd_lvl,
   output logic                     shift_o,
   output logic                     store_o,
   output logic                     clear_o,
   output logic [LANES-1:0]         data_o,
   output logic                     busy
);
   initial begin
      assert (LANES >= 1 && LANES <= 16) else $fatal(1, "LANES must be 1..16");
      assert (MAXBITS >= 1) else $fatal(1, "MAXBITS must be at least 1");
      assert (HALF_CYC >= 1 && STORE_CYC >= 1 && CLEAR_CYC >= 1)
         else $fatal(1, "phase lengths must be at least 1");
   end

   logic [CW-1:0]    nb_eff;
   logic             lane_load, lane_wr, lane_adv, sel_sr;
   logic             sclk_l, store_l, clear_l;
   logic [LANES-1:0] dat_l;

   sipo_ldr_ctrl #(
      .MAXBITS  (MAXBITS),
      .HALF_CYC (HALF_CYC),
      .STORE_CYC(STORE_CYC),
      .CLEAR_CYC(CLEAR_CYC),
      .CW       (CW)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd_op   (cmd_op),
      .cmd_bits (cmd_bits),
      .nb_eff   (nb_eff),
      .lane_load(lane_load),
      .lane_wr  (lane_wr),
      .lane_adv (lane_adv),
      .sel_sr   (sel_sr),
      .sclk_l   (sclk_l),
      .store_l  (store_l),
      .clear_l  (clear_l),
      .busy     (busy)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      sipo_ldr_lane #(.MAXBITS(MAXBITS), .CW(CW)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (lane_load),
         .wr    (lane_wr),
         .adv   (lane_adv),
         .sel_sr(sel_sr),
         .nb    (nb_eff),
         .word  (cmd_data[i*MAXBITS +: MAXBITS]),
         .lvl   (cmd_lvl[i]),
         .dline (dat_l[i])
      );
   end

   // polarity is applied only at the pins
   assign shift_o = SHIFT_ACT ? sclk_l  : ~sclk_l;
   assign store_o = STORE_ACT ? store_l : ~store_l;
   assign clear_o = CLEAR_ACT ? clear_l : ~clear_l;
   assign data_o  = dat_l ^ DATA_INV;
endmodule

// File: rtl/sipo_ldr_chk.sv
module sipo_ldr_chk #(
   parameter int               LANES     = 4,
   parameter bit               SHIFT_ACT = 1'b1,
   parameter bit               STORE_ACT = 1'b1,
   parameter bit               CLEAR_ACT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             shift_o,
   input logic             store_o,
   input logic             clear_o,
   input logic [LANES-1:0] data_o,
   input logic             busy
);
   logic sh, st, cl;
   assign sh = (shift_o == SHIFT_ACT);
   assign st = (store_o == STORE_ACT);
   assign cl = (clear_o == CLEAR_ACT);

   // R5
   no_store_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sh && st));

   // R7
   clear_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cl |-> (!sh && !st && busy));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sh && !st && !cl));

   // R3
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sh && $past(sh)) |-> $stable(data_o));

   // R4
   trail_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st && $past(st)) |-> $stable(data_o));

   // R5
   store_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st) |-> !busy);
endmodule

bind sipo_ldr sipo_ldr_chk #(
   .LANES    (LANES),
   .SHIFT_ACT(SHIFT_ACT),
   .STORE_ACT(STORE_ACT),
   .CLEAR_ACT(CLEAR_ACT)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .shift_o(shift_o),
   .store_o(store_o),
   .clear_o(clear_o),
   .data_o (data_o),
   .busy   (busy)
);

// File: tb/sipo_ldr_tb.sv
`timescale 1ns/1ps
module sipo_ldr_tb;
   localparam int         LN   = 3;
   localparam int         MB   = 8;
   localparam int         HC   = 2;
   localparam int         SC   = 3;
   localparam int         CC   = 2;
   localparam bit         SH_A = 1'b0;
   localparam bit         ST_A = 1'b1;
   localparam bit         CL_A = 1'b0;
   localparam logic [2:0] INV  = 3'b010;

   // {bits[30:27], lane2/lane1/lane0 words[26:3], levels[2:0]}
   localparam logic [30:0] VEC [6] = '{
      {4'd8,  24'hA53CF0, 3'b101},
      {4'd1,  24'h010001, 3'b010},
      {4'd5,  24'h130A1F, 3'b111},
      {4'd0,  24'hFFFFFF, 3'b000},
      {4'd11, 24'h817EC3, 3'b001},
      {4'd3,  24'h050207, 3'b100}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [3:0]    cmd_bits = '0;
   logic [23:0]   cmd_data = '0;
   logic [2:0]    cmd_lvl = '0;
   logic          shift_o, store_o, clear_o, busy;
   logic [2:0]    data_o;
   int            n_chk = 0;
   int            n_bad = 0;

   always #4 clk = ~clk;

   sipo_ldr #(
      .LANES(LN), .MAXBITS(MB), .HALF_CYC(HC), .STORE_CYC(SC), .CLEAR_CYC(CC),
      .SHIFT_ACT(SH_A), .STORE_ACT(ST_A), .CLEAR_ACT(CL_A), .DATA_INV(INV)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_bits(cmd_bits), .cmd_data(cmd_data), .cmd_lvl(cmd_lvl),
      .shift_o(shift_o), .store_o(store_o), .clear_o(clear_o),
      .data_o(data_o), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // run one load; poke > 0 offers a direct write at that busy sample
   task automatic run_load(input logic [30:0] v, input int poke);
      int         nb, ne, cyc, edges, stab, hrun, stcnt;
      bit         setup_bad, hi_bad, trail_bad, psh, sh, st;
      logic [2:0] dv, prev;
      logic [7:0] cap [3];
      logic [7:0] expw;
      bit         cap_ok;
      nb = int'(v[30:27]);
      ne = (nb > MB) ? MB : nb;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b01; cmd_bits = v[30:27];
      cmd_data = v[26:3]; cmd_lvl = v[2:0];
      prev = data_o ^ INV;
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc = 0; edges = 0; stab = 0; hrun = 0; stcnt = 0;
      setup_bad = 0; hi_bad = 0; trail_bad = 0; psh = 0;
      for (int l = 0; l < 3; l++) cap[l] = '0;
      while (busy && cyc < 1000) begin
         sh = (shift_o == SH_A);
         st = (store_o == ST_A);
         dv = data_o ^ INV;
         if (dv == prev) stab++; else stab = 0;
         prev = dv;
         if (sh && !psh) begin
            edges++;
            if (stab < HC) setup_bad = 1;
            for (int l = 0; l < 3; l++) cap[l] = {cap[l][6:0], dv[l]};
         end
         if (sh) hrun++;
         if (!sh && psh) begin
            if (hrun != HC) hi_bad = 1;
            hrun = 0;
         end
         if (st) begin
            stcnt++;
            if (dv != v[2:0]) trail_bad = 1;
         end
         psh = sh;
         if (poke > 0 && cyc == poke) begin
            cmd_valid = 1'b1; cmd_op = 2'b10; cmd_lvl = ~v[2:0];
         end else cmd_valid = 1'b0;
         cyc++;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      if (psh && hrun != HC) hi_bad = 1;
      // R3 busy duration
      chk(cyc == 2*HC*ne + HC + SC, "R3 busy length", cyc, 2*HC*ne + HC + SC);
      // R2 / R10 / R11 pulse count
      chk(edges == ne, "R2 shift pulse count", edges, ne);
      cap_ok = 1;
      for (int l = 0; l < 3; l++) begin
         expw = (ne == 0) ? 8'h00 : (v[3+8*l +: 8] & 8'((9'd1 << ne) - 9'd1));
         if (cap[l] != expw) cap_ok = 0;
      end
      // R2 / R11 bit order, all lanes
      chk(cap_ok, "R2 shifted bits", {8'h0, cap[2], cap[1], cap[0]}, int'(v[26:3]));
      chk(!setup_bad && !hi_bad, "R3 setup and shift width", {setup_bad, hi_bad}, 0);
      chk(stcnt == SC, "R5 store width", stcnt, SC);
      chk(!trail_bad, "R4 trailing levels at store", trail_bad, 0);
      // R4 / R8 levels left on the lines
      chk((data_o ^ INV) == v[2:0], poke > 0 ? "R8 ignored write" : "R4 idle levels",
          int'(data_o ^ INV), int'(v[2:0]));
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cyc, clc;
      bit other;
      repeat (3) @(negedge clk);
      // R1 / R9 reset levels
      chk(shift_o == ~SH_A && store_o == ~ST_A && clear_o == ~CL_A,
          "R1 R9 idle strobes", {shift_o, store_o, clear_o}, {~SH_A, ~ST_A, ~CL_A});
      chk(data_o == INV && !busy, "R1 R9 data and busy", {busy, data_o}, {1'b0, INV});
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 6; i++) run_load(VEC[i], 0);

      // R6 direct write
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b10; cmd_lvl = 3'b110;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk((data_o ^ INV) == 3'b110, "R6 direct levels", int'(data_o ^ INV), 6);
      chk(!busy && shift_o == ~SH_A && store_o == ~ST_A, "R6 no activity",
          {busy, shift_o, store_o}, {1'b0, ~SH_A, ~ST_A});

      // R7 clear pulse
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b11;
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc = 0; clc = 0; other = 0;
      while (busy && cyc < 100) begin
         if (clear_o == CL_A) clc++;
         if (shift_o == SH_A || store_o == ST_A) other = 1;
         cyc++;
         @(negedge clk);
      end
      chk(cyc == CC && clc == CC && !other, "R7 clear pulse", clc, CC);
      chk(clear_o == ~CL_A && (data_o ^ INV) == 3'b110, "R7 clear released",
          {clear_o, data_o ^ INV}, {~CL_A, 3'b110});

      // R8 direct write offered mid-load
      run_load({4'd6, 24'h2D1B35, 3'b011}, 3);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule